// File: doc/BRIEF.md
# Instruction Fetch Block Buffer

This block sits in front of a level-one instruction cache and keeps a handful of recently used cache lines. The fetch unit hands it one word-aligned address at a time over a valid/ready handshake. The buffer walks its entries one per cycle and compares each entry's key against the request. The key is the cache's set index together with its tag. When an entry matches, the buffer returns the requested word straight from its own storage, and the cache is never touched.

When no entry matches, the buffer sends a single line request to the cache port and waits for the line. It returns the requested word in the cycle the line arrives, and it installs the line into a victim entry. The victim is an empty entry if one exists; otherwise it is the entry least recently used. There is no address decoder: an entry can be located only by comparing keys. A flush input empties the buffer in one cycle, and two event counters record hits and misses.

Top module: `ifetch_blkbuf`

## Requirements
- R1: A fetch that hits in the buffer never raises `l1_req_valid` at any point between its acceptance and its response.
- R2: With the default geometry, address bits [4:2] pick the word in a line, bits [10:5] are the set index and bits [31:11] are the tag. Each entry is keyed by set and tag together, so two lines that share only a set or only a tag occupy separate entries.
- R3: A line is never held in two valid entries at the same time. Repeated fetches of a resident line do not consume extra entries.
- R4: Entries are examined in ascending index order, one per cycle. A hit in entry i responds in cycle i+1 after the accepting edge. After a reset or a flush, fills use the lowest free index first.
- R5: A miss is declared only after all ENTRIES entries have been examined. `l1_req_valid` is then high for exactly one cycle, in cycle ENTRIES+1 after acceptance, and carries the line-aligned request address.
- R6: On a miss, `rsp_valid` and the requested word appear in the same cycle as `l1_rsp_valid`. The line is installed, so a later fetch of that line hits.
- R7: When every entry is valid, a miss replaces the least recently used entry. Both fills and hits count as uses.
- R8: A one-cycle `flush` pulse invalidates every entry. The next fetch of any previously held line misses.
- R9: After reset, `req_ready` is 1, `rsp_valid` and `l1_req_valid` are 0, and both counters read 0.
- R10: Only one fetch is outstanding at a time: `req_ready` stays 0 from acceptance until the response. `hit_count` and `miss_count` advance once per hit and once per miss, so `miss_count` equals the number of line requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Buffer idle, request accepted when both high |
| req_addr | input | ADDR_BITS | Fetch byte address (word aligned) |
| rsp_valid | output | 1 | Fetched word valid this cycle |
| rsp_data | output | WORD_BITS | Fetched word |
| l1_req_valid | output | 1 | One-cycle line request to the cache |
| l1_req_addr | output | ADDR_BITS | Line-aligned request address |
| l1_rsp_valid | input | 1 | Line from the cache valid |
| l1_rsp_line | input | LINE_BYTES*8 | Returned line, word 0 in the low bits |
| hit_count | output | CNT_BITS | Hits since reset |
| miss_count | output | CNT_BITS | Misses since reset |

## Verification
The bench measures the response cycle of each hit against the entry the requirements place the line in. A search that skipped entries, ran in the wrong order or compared in parallel would show a latency that does not match. It fills the buffer and then replays a fixed access order, checking which line gets evicted. A wrong age update would evict a recently used line and turn an expected hit into a miss. It also pairs addresses that share only a set index or only a tag; a buffer keyed on one field alone would report false hits with the wrong data. Repeated hits followed by fills, and a flush followed by a refetch, expose duplicate installs and stale valid bits as shifted entry positions.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

    typedef enum logic [1:0] {
        BB_IDLE,
        BB_SEARCH,
        BB_ISSUE,
        BB_WAIT
    } bb_state_e;

    // Index width for a structure of n items, never below one bit.
    function automatic int bb_idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/blkbuf_store.sv
module blkbuf_store #(
    parameter int N         = 4,
    parameter int IW        = 2,
    parameter int KEY_BITS  = 27,
    parameter int LINE_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [KEY_BITS-1:0]  wr_key,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic [IW-1:0]        rd_idx,
    output logic                 rd_valid,
    output logic [KEY_BITS-1:0]  rd_key,
    output logic [LINE_BITS-1:0] rd_line,
    output logic [N-1:0]         valid_vec
);

    logic [N-1:0]         valid_q;
    logic [KEY_BITS-1:0]  key_q  [N];
    logic [LINE_BITS-1:0] line_q [N];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx]  <= wr_key;
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_key    = key_q[rd_idx];
    assign rd_line   = line_q[rd_idx];
    assign valid_vec = valid_q;

    logic dup_found;
    always_comb begin
        dup_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (valid_q[i] && valid_q[j] && key_q[i] == key_q[j])
                    dup_found = 1'b1;
            end
        end
    end

    // R3
    no_dup_key_chk: assert property (@(posedge clk) disable iff (rst) !dup_found);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R6
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/blkbuf_lru.sv
module blkbuf_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [N-1:0]  valid_vec,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);

    localparam logic [IW-1:0] AGE_MAX = IW'(N - 1);

    logic [IW-1:0] age_q [N];
    logic [IW-1:0] cur_age;

    // An empty entry counts as the oldest, so every valid entry ages on its fill.
    assign cur_age = valid_vec[touch_idx] ? age_q[touch_idx] : AGE_MAX;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N; i++) age_q[i] <= '0;
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (valid_vec[i] && age_q[i] < cur_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    logic [N-1:0] oldest_mask;
    logic         free_found;

    always_comb begin
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            oldest_mask[i] = (age_q[i] == AGE_MAX);
            if (!free_found && !valid_vec[i]) begin
                victim_idx = IW'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++) begin
                if (oldest_mask[i]) victim_idx = IW'(i);
            end
        end
    end

    // R7
    single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (&valid_vec) |-> ($countones(oldest_mask) == 1));

endmodule

// File: rtl/blkbuf_ctrl.sv
module blkbuf_ctrl
    import blkbuf_pkg::*;
#(
    parameter int N         = 4,
    parameter int IW        = 2,
    parameter int ADDR_BITS = 32,
    parameter int WORD_BITS = 32,
    parameter int LINE_BITS = 256,
    parameter int BOFF_BITS = 2,
    parameter int WOFF_BITS = 3,
    parameter int KEY_BITS  = 27,
    parameter int CNT_BITS  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_BITS-1:0] req_addr,
    output logic                 rsp_valid,
    output logic [WORD_BITS-1:0] rsp_data,
    output logic                 l1_req_valid,
    output logic [ADDR_BITS-1:0] l1_req_addr,
    input  logic                 l1_rsp_valid,
    input  logic [LINE_BITS-1:0] l1_rsp_line,
    output logic [IW-1:0]        rd_idx,
    input  logic                 rd_valid,
    input  logic [KEY_BITS-1:0]  rd_key,
    input  logic [LINE_BITS-1:0] rd_line,
    input  logic [IW-1:0]        victim_idx,
    output logic                 wr_en,
    output logic [KEY_BITS-1:0]  wr_key,
    output logic                 touch_en,
    output logic [IW-1:0]        touch_idx,
    output logic [CNT_BITS-1:0]  hit_count,
    output logic [CNT_BITS-1:0]  miss_count
);

    localparam int OFF_BITS = BOFF_BITS + WOFF_BITS;
    localparam int WPL      = LINE_BITS / WORD_BITS;
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    bb_state_e                 state_q;
    logic [IW-1:0]             idx_q;
    logic [KEY_BITS-1:0]       key_q;
    logic [WOFF_BITS-1:0]      wsel_q;
    logic [CNT_BITS-1:0]       hits_q, misses_q;

    logic unused_byte_off;
    assign unused_byte_off = ^req_addr[BOFF_BITS-1:0];

    logic match, fill;
    assign match = (state_q == BB_SEARCH) && rd_valid && (rd_key == key_q);
    assign fill  = (state_q == BB_WAIT) && l1_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BB_IDLE;
            idx_q    <= '0;
            key_q    <= '0;
            wsel_q   <= '0;
            hits_q   <= '0;
            misses_q <= '0;
        end else begin
            case (state_q)
                BB_IDLE: if (req_valid) begin
                    state_q <= BB_SEARCH;
                    idx_q   <= '0;
                    key_q   <= req_addr[ADDR_BITS-1:OFF_BITS];
                    wsel_q  <= req_addr[OFF_BITS-1:BOFF_BITS];
                end
                BB_SEARCH: begin
                    if (match) begin
                        state_q <= BB_IDLE;
                        hits_q  <= hits_q + 1'b1;
                    end else if (idx_q == LAST_IDX) begin
                        state_q  <= BB_ISSUE;
                        misses_q <= misses_q + 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                BB_ISSUE: state_q <= BB_WAIT;
                BB_WAIT:  if (l1_rsp_valid) state_q <= BB_IDLE;
                default:  state_q <= BB_IDLE;
            endcase
        end
    end

    // Word selection from either the stored line or the arriving one.
    logic [LINE_BITS-1:0] src_line;
    logic [WORD_BITS-1:0] words [WPL];
    assign src_line = match ? rd_line : l1_rsp_line;

    for (genvar w = 0; w < WPL; w++) begin : g_word
        assign words[w] = src_line[w*WORD_BITS +: WORD_BITS];
    end

    assign req_ready    = (state_q == BB_IDLE);
    assign rsp_valid    = match || fill;
    assign rsp_data     = words[wsel_q];
    assign l1_req_valid = (state_q == BB_ISSUE);
    assign l1_req_addr  = {key_q, {OFF_BITS{1'b0}}};
    assign rd_idx       = idx_q;
    assign wr_en        = fill;
    assign wr_key       = key_q;
    assign touch_en     = match || fill;
    assign touch_idx    = match ? idx_q : victim_idx;
    assign hit_count    = hits_q;
    assign miss_count   = misses_q;

    // R5
    one_cycle_req_chk: assert property (@(posedge clk) disable iff (rst)
        l1_req_valid |=> !l1_req_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    hit_no_l1_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> (!l1_req_valid && req_ready));

endmodule

// File: rtl/ifetch_blkbuf.sv
module ifetch_blkbuf
    import blkbuf_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BITS  = 32,
    parameter int SET_BITS   = 6,
    parameter int ADDR_BITS  = 32,
    parameter int CNT_BITS   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_BITS-1:0]    req_addr,
    output logic                    rsp_valid,
    output logic [WORD_BITS-1:0]    rsp_data,
    output logic                    l1_req_valid,
    output logic [ADDR_BITS-1:0]    l1_req_addr,
    input  logic                    l1_rsp_valid,
    input  logic [LINE_BYTES*8-1:0] l1_rsp_line,
    output logic [CNT_BITS-1:0]     hit_count,
    output logic [CNT_BITS-1:0]     miss_count
);

    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int WPL       = LINE_BITS / WORD_BITS;
    localparam int BOFF_BITS = $clog2(WORD_BITS / 8);
    localparam int WOFF_BITS = bb_idx_w(WPL);
    localparam int TAG_BITS  = ADDR_BITS - SET_BITS - WOFF_BITS - BOFF_BITS;
    localparam int KEY_BITS  = TAG_BITS + SET_BITS;
    localparam int IW        = bb_idx_w(ENTRIES);

    logic [IW-1:0]        rd_idx, victim_idx, touch_idx;
    logic                 rd_valid, wr_en, touch_en;
    logic [KEY_BITS-1:0]  rd_key, wr_key;
    logic [LINE_BITS-1:0] rd_line;
    logic [ENTRIES-1:0]   valid_vec;

    blkbuf_ctrl #(
        .N(ENTRIES), .IW(IW), .ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS),
        .LINE_BITS(LINE_BITS), .BOFF_BITS(BOFF_BITS), .WOFF_BITS(WOFF_BITS),
        .KEY_BITS(KEY_BITS), .CNT_BITS(CNT_BITS)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .l1_req_valid(l1_req_valid), .l1_req_addr(l1_req_addr),
        .l1_rsp_valid(l1_rsp_valid), .l1_rsp_line(l1_rsp_line),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_key(rd_key), .rd_line(rd_line),
        .victim_idx(victim_idx), .wr_en(wr_en), .wr_key(wr_key),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    blkbuf_store #(
        .N(ENTRIES), .IW(IW), .KEY_BITS(KEY_BITS), .LINE_BITS(LINE_BITS)
    ) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(wr_en), .wr_idx(victim_idx), .wr_key(wr_key), .wr_line(l1_rsp_line),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_key(rd_key), .rd_line(rd_line),
        .valid_vec(valid_vec)
    );

    blkbuf_lru #(
        .N(ENTRIES), .IW(IW)
    ) u_lru (
        .clk(clk), .rst(rst), .flush(flush),
        .valid_vec(valid_vec), .touch_en(touch_en), .touch_idx(touch_idx),
        .victim_idx(victim_idx)
    );

endmodule

// File: tb/ifetch_blkbuf_tb.sv
`timescale 1ns/1ps
module ifetch_blkbuf_tb;

    localparam int N  = 4;
    localparam int LB = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          l1_req_valid;
    logic [31:0]   l1_req_addr;
    logic          l1_rsp_valid = 1'b0;
    logic [LB-1:0] l1_rsp_line = '0;
    logic [15:0]   hit_count, miss_count;

    int n_tests = 0, n_fail = 0;
    int l1_reqs = 0, tb_hits = 0, busy_bad = 0;

    always #2.5 clk = ~clk;

    ifetch_blkbuf u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .l1_req_valid(l1_req_valid), .l1_req_addr(l1_req_addr),
        .l1_rsp_valid(l1_rsp_valid), .l1_rsp_line(l1_rsp_line),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [LB-1:0] make_line(input logic [31:0] base);
        logic [LB-1:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = exp_word(base + 32'(w * 4));
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One fetch with a cache model that answers two cycles after a request.
    task automatic fetch(input logic [31:0] a, output bit hit, output int lat,
                         output int req_lat, output logic [31:0] data, output int nreq);
        bit done = 0;
        hit = 0; lat = 0; req_lat = -1; data = '0; nreq = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1 req_valid = 1'b0;
        while (!done && lat < 60) begin
            @(negedge clk); lat++;
            if (l1_req_valid) begin
                nreq++; l1_reqs++; req_lat = lat;
                check(l1_req_addr == {a[31:5], 5'b0}, "R5", "line request address",
                      64'(l1_req_addr), 64'({a[31:5], 5'b0}));
                repeat (2) begin @(negedge clk); lat++; if (l1_req_valid) nreq++; end
                l1_rsp_line = make_line({a[31:5], 5'b0});
                l1_rsp_valid = 1'b1;
                #1;
                check(rsp_valid == 1'b1, "R6", "word with arriving line", 64'(rsp_valid), 64'd1);
                data = rsp_data; done = 1;
                @(posedge clk); #1 l1_rsp_valid = 1'b0;
            end else if (rsp_valid) begin
                hit = 1; data = rsp_data; done = 1; tb_hits++;
            end else if (req_ready) begin
                busy_bad++;
            end
        end
    endtask

    // exp_lat: hit cycle (entry index + 1); ignored for misses.
    task automatic expect_fetch(input logic [31:0] a, input bit exp_hit,
                                input int exp_lat, input string req);
        bit hit; int lat, rl, nreq; logic [31:0] d;
        fetch(a, hit, lat, rl, d, nreq);
        check(hit == exp_hit, req, $sformatf("hit flag for %h", a), 64'(hit), 64'(exp_hit));
        if (exp_hit) begin
            check(nreq == 0, "R1", "cache request on hit", 64'(nreq), 64'd0);
            check(lat == exp_lat, "R4", $sformatf("hit latency for %h", a), 64'(lat), 64'(exp_lat));
        end else begin
            check(rl == N + 1, "R5", "miss request cycle", 64'(rl), 64'(N + 1));
            check(nreq == 1, "R5", "single line request", 64'(nreq), 64'd1);
        end
        check(d == exp_word(a), req, $sformatf("data for %h", a), 64'(d), 64'(exp_word(a)));
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(posedge clk); #1 flush = 1'b0;
    endtask

    localparam logic [31:0] A  = 32'h0000_1040;
    localparam logic [31:0] B  = 32'h0000_2080;
    localparam logic [31:0] C  = 32'h0000_30C0;
    localparam logic [31:0] D  = 32'h0000_4100;
    localparam logic [31:0] E  = 32'h0000_5140;
    localparam logic [31:0] S1 = 32'h0001_0040;  // same set as A, other tag
    localparam logic [31:0] T1 = 32'h0000_1060;  // same tag as A, other set

    task automatic t_reset();
        check(req_ready == 1'b1, "R9", "req_ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(l1_req_valid == 1'b0, "R9", "l1_req_valid after reset", 64'(l1_req_valid), 64'd0);
        check(hit_count == 0 && miss_count == 0, "R9", "counters after reset",
              64'({hit_count, miss_count}), 64'd0);
    endtask

    task automatic t_miss_then_hit();
        expect_fetch(A + 32'h08, 1'b0, 0, "R6");
        expect_fetch(A + 32'h1C, 1'b1, 1, "R1");
        expect_fetch(A, 1'b1, 1, "R6");
    endtask

    task automatic t_search_order();
        expect_fetch(B, 1'b0, 0, "R4");
        expect_fetch(C + 32'h4, 1'b0, 0, "R4");
        expect_fetch(D, 1'b0, 0, "R4");
        expect_fetch(D + 32'h4, 1'b1, 4, "R4");
        expect_fetch(B + 32'h10, 1'b1, 2, "R4");
    endtask

    task automatic t_lru();
        // use order oldest->newest: A C D B; E evicts A (entry 0)
        expect_fetch(E, 1'b0, 0, "R7");
        expect_fetch(A, 1'b0, 0, "R7");        // evicts C (entry 2)
        expect_fetch(E, 1'b1, 1, "R7");
        expect_fetch(A + 32'h4, 1'b1, 3, "R7");
        expect_fetch(D, 1'b1, 4, "R7");
        expect_fetch(B, 1'b1, 2, "R7");
        expect_fetch(C, 1'b0, 0, "R7");        // evicts E (entry 0)
        expect_fetch(E, 1'b0, 0, "R7");        // evicts A (entry 2)
        expect_fetch(C, 1'b1, 1, "R7");
        expect_fetch(E, 1'b1, 3, "R7");
    endtask

    task automatic t_keying();
        do_flush();
        expect_fetch(A, 1'b0, 0, "R2");
        expect_fetch(S1 + 32'h8, 1'b0, 0, "R2");
        expect_fetch(T1 + 32'hC, 1'b0, 0, "R2");
        expect_fetch(A + 32'h14, 1'b1, 1, "R2");
        expect_fetch(S1, 1'b1, 2, "R2");
        expect_fetch(T1, 1'b1, 3, "R2");
    endtask

    task automatic t_no_dup();
        do_flush();
        expect_fetch(B, 1'b0, 0, "R3");
        for (int k = 1; k < 5; k++) expect_fetch(B + 32'(k * 4), 1'b1, 1, "R3");
        expect_fetch(C, 1'b0, 0, "R3");
        expect_fetch(D, 1'b0, 0, "R3");
        expect_fetch(E, 1'b0, 0, "R3");
        expect_fetch(E + 32'h18, 1'b1, 4, "R3");
    endtask

    task automatic t_flush();
        expect_fetch(D, 1'b1, 3, "R8");
        do_flush();
        expect_fetch(D, 1'b0, 0, "R8");
        expect_fetch(D + 32'h4, 1'b1, 1, "R8");
        expect_fetch(E, 1'b0, 0, "R8");
    endtask

    task automatic t_counters();
        @(negedge clk);
        check(miss_count == 16'(l1_reqs), "R10", "miss count vs cache requests",
              64'(miss_count), 64'(l1_reqs));
        check(hit_count == 16'(tb_hits), "R10", "hit count", 64'(hit_count), 64'(tb_hits));
        check(busy_bad == 0, "R10", "req_ready while busy", 64'(busy_bad), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_search_order();
        t_lru();
        t_keying();
        t_no_dup();
        t_flush();
        t_counters();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule